// File: doc/BRIEF.md
# Byte-Wise Serial DAC Frame Master

This block sits on the host side of a three-wire link to a serial DAC. It accepts a 12-bit conversion code, forms a 16-bit frame whose top four bits carry no meaning, and sends that frame through an internal engine that can shift only 8-bit bytes, least significant buffer bit first. Each byte image is bit-reversed before it is loaded. On the wire the four padding bits therefore come first, then the code from its MSB down, and the code LSB is the last bit sent. The frame-sync line goes low before the first byte and stays low across the byte boundary. It returns high only once the second byte has finished.

The block makes the serial clock from the system clock with a programmable half-period divider. The serial clock idles high. Serial data changes only on rising serial-clock edges, so it is stable at every falling edge, where the DAC samples. Two load modes are offered. In automatic mode the load line is held low and the DAC updates on its own at the sixteenth falling edge. In timer mode a configurable delay follows the frame, then the load line pulses low for a configurable number of cycles. A one-cycle done pulse marks the end of each transaction.

Top module: `dac_frame_tx`

## Requirements
- R1: After reset, sclk, sync_n and ldac_n are high and busy and done are low. The serial clock stays high whenever busy is low.
- R2: One accepted frame gives exactly 16 falling sclk edges while sync_n is low. The bits seen at those edges, in order, are four 0 padding bits, then code[11] down to code[0].
- R3: sync_n stays low between the eighth and ninth falling edges, and sclk never falls while sync_n is high.
- R4: Every sclk low phase lasts max(half_div,1) system cycles. The first falling edge comes max(half_div,1) cycles after sync_n falls.
- R5: sdata does not change while sclk stays low.
- R6: sync_n rises max(half_div,1) cycles after the sixteenth falling edge, in the same cycle as the final sclk rise.
- R7: start is accepted only while busy is low. A start while busy is ignored: the frame in flight keeps its bits and no extra frame follows.
- R8: With load_mode=0 (automatic), ldac_n is low from the accepted start onward, and done pulses for one cycle in the cycle that sync_n rises.
- R9: With load_mode=1 (timer), ldac_n falls load_delay+1 cycles after sync_n rises and stays low for max(load_width,1) cycles. done pulses for one cycle in the cycle ldac_n rises.
- R10: busy is high from the cycle after an accepted start until the cycle that done is high, in which it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send one frame |
| code | input | 12 | DAC code, sampled with an accepted start |
| load_mode | input | 1 | 0 = automatic update, 1 = timer-driven load pulse |
| half_div | input | 8 | Serial clock half period in system cycles (0 acts as 1) |
| load_delay | input | 8 | Cycles after sync release before the load pulse, minus one |
| load_width | input | 8 | Load pulse length in cycles (0 acts as 1) |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, stable at sclk falling edges |
| sync_n | output | 1 | Active-low frame sync |
| ldac_n | output | 1 | Active-low DAC load line |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The bench targets the byte boundary. A design that released sync or lost the bit order there would show fewer than sixteen falls in one sync window, or a wrongly ordered word with the code LSB not last. It drives the divider and timer settings of zero and one. Mishandling these gives setup times, low phases or load pulses that are off by one, or a pulse of zero length. It also sends extreme codes with padding on both sides, and a start that arrives mid-frame. If that start were accepted, the bits would be corrupted or a second frame would appear.

// File: rtl/dft_pkg.sv
package dft_pkg;
  localparam int CODE_W  = 12;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = 2;
  localparam int FRAME_W = NBYTES * BYTE_W;
  localparam int PAD_W   = FRAME_W - CODE_W;
  localparam int BIT_IW  = $clog2(BYTE_W);
  localparam int BYTE_IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP, ST_PULSE} dft_state_e;

  // Padding bits sit above the code; frame MSB is the first bit on the wire.
  function automatic logic [FRAME_W-1:0] frame_of(input logic [CODE_W-1:0] c);
    return {{PAD_W{1'b0}}, c};
  endfunction

  // Image of byte slot idx as the LSB-first engine must hold it:
  // buffer bit b is the frame bit sent b-th within that byte.
  function automatic logic [BYTE_W-1:0] lsb_first_image(
      input logic [FRAME_W-1:0] f, input int unsigned idx);
    logic [BYTE_W-1:0] img;
    for (int b = 0; b < BYTE_W; b++) img[b] = f[FRAME_W-1-idx*BYTE_W-b];
    return img;
  endfunction
endpackage

// File: rtl/dft_clk_div.sv
module dft_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  function automatic logic [DIV_W-1:0] half_limit(input logic [DIV_W-1:0] h);
    return (h == '0) ? '0 : h - 1'b1;
  endfunction

  assign lim  = half_limit(half);
  assign tick = en && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dft_byte_shifter.sv
module dft_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         sdata
);
  logic [W-1:0] buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     buf_q <= '0;
    else if (load)  buf_q <= load_val;
    else if (shift) buf_q <= {1'b0, buf_q[W-1:1]};
  end

  assign sdata = buf_q[0];

  // R2
  no_load_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/dft_frame_ctrl.sv
module dft_frame_ctrl
  import dft_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TMR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  input  logic              load_mode,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [TMR_W-1:0]  load_delay,
  input  logic [TMR_W-1:0]  load_width,
  input  logic              tick,
  output logic              div_en,
  output logic [DIV_W-1:0]  half_q,
  output logic              ld,
  output logic [BYTE_W-1:0] ld_val,
  output logic              sh,
  output logic              sclk_o,
  output logic              sync_n_o,
  output logic              ldac_n_o,
  output logic              busy,
  output logic              done
);
  localparam logic [BIT_IW-1:0]  LAST_BIT  = BIT_IW'(BYTE_W - 1);
  localparam logic [BYTE_IW-1:0] LAST_BYTE = BYTE_IW'(NBYTES - 1);

  dft_state_e         st;
  logic [FRAME_W-1:0] frame_r;
  logic [TMR_W-1:0]   dly_r, wid_r, cnt;
  logic [BIT_IW-1:0]  bit_i;
  logic [BYTE_IW-1:0] byte_i;
  logic               sclk_r, sync_r, ldac_r, auto_r, done_r;

  // named internal events
  logic accept, rise_evt, fall_evt, byte_turn, frame_end;

  function automatic logic [TMR_W-1:0] width_load(input logic [TMR_W-1:0] w);
    return (w == '0) ? '0 : w - 1'b1;
  endfunction

  assign accept    = start && (st == ST_IDLE);
  assign fall_evt  = (st == ST_SHIFT) && tick && sclk_r;
  assign rise_evt  = (st == ST_SHIFT) && tick && !sclk_r;
  assign byte_turn = rise_evt && (bit_i == LAST_BIT) && (byte_i != LAST_BYTE);
  assign frame_end = rise_evt && (bit_i == LAST_BIT) && (byte_i == LAST_BYTE);

  assign ld     = accept || byte_turn;
  assign ld_val = accept ? lsb_first_image(frame_of(code), 0)
                         : lsb_first_image(frame_r, int'(byte_i) + 1);
  assign sh     = rise_evt && (bit_i != LAST_BIT);
  assign div_en = (st == ST_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      frame_r <= '0;
      half_q  <= '0;
      dly_r   <= '0;
      wid_r   <= '0;
      cnt     <= '0;
      bit_i   <= '0;
      byte_i  <= '0;
      sclk_r  <= 1'b1;
      sync_r  <= 1'b1;
      ldac_r  <= 1'b1;
      auto_r  <= 1'b0;
      done_r  <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          frame_r <= frame_of(code);
          half_q  <= half_div;
          dly_r   <= load_delay;
          wid_r   <= load_width;
          auto_r  <= !load_mode;
          ldac_r  <= 1'b1;
          sync_r  <= 1'b0;
          sclk_r  <= 1'b1;
          bit_i   <= '0;
          byte_i  <= '0;
          st      <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (fall_evt) sclk_r <= 1'b0;
          if (rise_evt) begin
            sclk_r <= 1'b1;
            if (bit_i != LAST_BIT) bit_i <= bit_i + 1'b1;
            else                   bit_i <= '0;
          end
          if (byte_turn) byte_i <= byte_i + 1'b1;
          if (frame_end) begin
            sync_r <= 1'b1;
            byte_i <= '0;
            if (auto_r) begin
              done_r <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              cnt <= dly_r;
              st  <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (cnt == '0) begin
            ldac_r <= 1'b0;
            cnt    <= width_load(wid_r);
            st     <= ST_PULSE;
          end else cnt <= cnt - 1'b1;
        end
        ST_PULSE: begin
          if (cnt == '0) begin
            ldac_r <= 1'b1;
            done_r <= 1'b1;
            st     <= ST_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o   = sclk_r;
  assign sync_n_o = sync_r;
  assign ldac_n_o = auto_r ? 1'b0 : ldac_r;
  assign busy     = (st != ST_IDLE);
  assign done     = done_r;

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk_o && sync_n_o));
  // R3
  sclk_fall_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> !sync_n_o);
  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(frame_r));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx #(
  parameter int DIV_W = 8,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [11:0]      code,
  input  logic             load_mode,
  input  logic [DIV_W-1:0] half_div,
  input  logic [TMR_W-1:0] load_delay,
  input  logic [TMR_W-1:0] load_width,
  output logic             sclk,
  output logic             sdata,
  output logic             sync_n,
  output logic             ldac_n,
  output logic             busy,
  output logic             done
);
  import dft_pkg::*;

  logic              div_en, tick, ld, sh;
  logic [DIV_W-1:0]  half_q;
  logic [BYTE_W-1:0] ld_val;

  dft_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(div_en), .half(half_q), .tick(tick));

  dft_byte_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
    .shift(sh), .sdata(sdata));

  dft_frame_ctrl #(.DIV_W(DIV_W), .TMR_W(TMR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code),
    .load_mode(load_mode), .half_div(half_div), .load_delay(load_delay),
    .load_width(load_width), .tick(tick), .div_en(div_en), .half_q(half_q),
    .ld(ld), .ld_val(ld_val), .sh(sh), .sclk_o(sclk), .sync_n_o(sync_n),
    .ldac_n_o(ldac_n), .busy(busy), .done(done));

  // R5
  sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |=> (sclk || $stable(sdata)));
endmodule

// File: tb/test_dac_frame_tx.sv
module test_dac_frame_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, load_mode = 0;
  logic [11:0] code = '0;
  logic [7:0] half_div = 8'd1, load_delay = '0, load_width = '0;
  logic sclk, sdata, sync_n, ldac_n, busy, done;

  int checks = 0, failures = 0;

  dac_frame_tx i_dac_frame_tx (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor state
  int cyc = 0, fall_cnt = 0, sync_falls = 0, bad_low = 0, sdata_bad = 0;
  int sync_fall_c = 0, first_fall_c = 0, last_fall_c = 0, sync_rise_c = 0;
  int ldac_fall_c = 0, ldac_rise_c = 0, done_c = 0, done_cnt = 0, low_start = 0;
  int h_eff = 1;
  logic [15:0] bits = '0;
  logic p_sclk = 1, p_sync = 1, p_ldac = 1, p_sdata = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_sync && !sync_n) begin
        sync_fall_c = cyc; fall_cnt = 0; bits = '0; sync_falls++;
      end
      if (p_sclk && !sclk && !sync_n) begin
        fall_cnt++;
        bits = {bits[14:0], sdata};
        if (fall_cnt == 1) first_fall_c = cyc;
        last_fall_c = cyc;
        low_start = cyc;
      end
      if (!p_sclk && sclk && (cyc - low_start != h_eff)) bad_low++;
      if (!p_sclk && !sclk && (sdata != p_sdata)) sdata_bad++;
      if (!p_sync && sync_n) sync_rise_c = cyc;
      if (p_ldac && !ldac_n) ldac_fall_c = cyc;
      if (!p_ldac && ldac_n) ldac_rise_c = cyc;
      if (done) begin done_c = cyc; done_cnt++; end
    end
    p_sclk = sclk; p_sync = sync_n; p_ldac = ldac_n; p_sdata = sdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wire_word(input logic [11:0] c);
    logic [15:0] w = '0;
    for (int i = 0; i < 12; i++) w[i] = c[i];
    return w;
  endfunction

  task automatic run_frame(input logic [11:0] c, input logic m, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] w, input bit inject);
    int old_done, old_falls, guard;
    int w_eff;
    w_eff = (w == 0) ? 1 : int'(w);
    h_eff = (h == 0) ? 1 : int'(h);
    old_done = done_cnt; old_falls = sync_falls;
    @(negedge clk);
    code = c; load_mode = m; half_div = h; load_delay = d; load_width = w; start = 1;
    @(negedge clk);
    start = 0;
    #1;
    check(busy == 1, "R10 busy after start", busy, 1);
    if (m == 0) check(ldac_n == 0, "R8 ldac low in auto frame", ldac_n, 0);
    if (inject) begin
      repeat (3) @(negedge clk);
      code = ~c; start = 1;
      @(negedge clk);
      start = 0;
    end
    guard = 0;
    while (done_cnt == old_done && guard < 5000) begin @(negedge clk); guard++; end
    check(guard < 5000, "R10 done reached", guard, 0);
    #1;
    check(busy == 0, "R10 busy low at done", busy, 0);
    check(fall_cnt == 16, "R2 falling edge count", fall_cnt, 16);
    check(bits == wire_word(c), "R2 frame bits", bits, wire_word(c));
    check(bad_low == 0, "R4 low phase length", bad_low, 0);
    check(first_fall_c - sync_fall_c == h_eff, "R4 setup", first_fall_c - sync_fall_c, h_eff);
    check(sdata_bad == 0, "R5 sdata stable while low", sdata_bad, 0);
    check(sync_rise_c - last_fall_c == h_eff, "R6 sync release", sync_rise_c - last_fall_c, h_eff);
    if (m == 0) begin
      check(done_c == sync_rise_c, "R8 done at sync rise", done_c, sync_rise_c);
      check(ldac_n == 0, "R8 ldac held low", ldac_n, 0);
    end else begin
      check(ldac_fall_c - sync_rise_c == int'(d) + 1, "R9 load delay",
            ldac_fall_c - sync_rise_c, int'(d) + 1);
      check(ldac_rise_c - ldac_fall_c == w_eff, "R9 load width",
            ldac_rise_c - ldac_fall_c, w_eff);
      check(done_c == ldac_rise_c, "R9 done at ldac rise", done_c, ldac_rise_c);
    end
    repeat (4) @(negedge clk);
    check(done_cnt == old_done + 1, "R9 single done", done_cnt - old_done, 1);
    check(sync_falls == old_falls + 1, "R7 one frame only", sync_falls - old_falls, 1);
    check(sclk == 1 && sync_n == 1, "R1 idle lines", {sclk, sync_n}, 3);
    bad_low = 0; sdata_bad = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1D5A);
    repeat (3) @(negedge clk);
    check(sclk == 1 && sync_n == 1 && ldac_n == 1, "R1 reset lines",
          {sclk, sync_n, ldac_n}, 7);
    check(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // directed corners
    run_frame(12'hFFF, 1'b0, 8'd1, 8'd0, 8'd1, 0);   // R2 all ones, R8
    run_frame(12'h000, 1'b1, 8'd0, 8'd0, 8'd0, 0);   // R4 half 0, R9 width 0
    run_frame(12'h801, 1'b1, 8'd3, 8'd5, 8'd4, 0);   // R3 byte boundary
    run_frame(12'hA5C, 1'b0, 8'd2, 8'd0, 8'd0, 1);   // R7 start while busy
    run_frame(12'h3C7, 1'b1, 8'd1, 8'd2, 8'd1, 1);   // R7 in timer mode
    // constrained random
    for (int i = 0; i < 20; i++) begin
      run_frame(12'($urandom), 1'($urandom), 8'($urandom % 5),
                8'($urandom % 6), 8'($urandom % 5), ($urandom % 4) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule